// File: doc/BRIEF.md
# Trigger-Tower Digital Filter and Energy Picker

This block turns the digitised pulse of one calorimeter trigger-tower channel into a single transverse-energy word per bunch crossing. ADC samples arrive four per crossing on one fast clock, each marked by a valid strobe, and a crossing strobe marks the first sample of every crossing. Every second sample (the first and third of each crossing) feeds an 8-tap FIR filter with signed, programmable coefficients. Its sum is clamped into an 11-bit unsigned range.

The filtered stream passes through a three-point local-maximum test. That test assigns the pulse to exactly one crossing. For that crossing an 8-bit energy word is read from a 2048-entry table indexed by the filtered value at the peak. Every other crossing gives zero. One word with a strobe comes out per crossing, ready for a downstream serialiser.

Coefficients and table contents are loaded through one address/data/write-enable port. The port only accepts writes while the run control is low.

Top module: `tt_filter_chain`

## Requirements
- R1: While rst_ni is low and after its release, before any sample is accepted, et_o is 0 and et_strobe_o is 0.
- R2: A sample accepted with xing_i high is phase 0 of a crossing, and each later accepted sample advances the phase modulo 4. Only phase 0 (early half) and phase 2 (late half) samples enter the filter. Phase 1 and 3 samples have no effect on any output.
- R3: For each filter input x[n] the filter output is sum over k=0..7 of c[k]*x[n-k]. x[n] is the newest filter input, and c[k] is a 6-bit two's complement coefficient. Filter history is zero after reset.
- R4: A filter sum above 2047 gives 2047, and a negative sum gives 0.
- R5: A filtered value y[m] is a peak when y[m] > y[m-1] and y[m] >= y[m+1]. A flat top of equal values therefore gives one peak, on its first value. A peak value is never 0.
- R6: A peak belongs to the crossing of its middle sample. That crossing outputs table[y[m]], and a crossing without a peak outputs 0.
- R7: At most one of the two filter outputs of a crossing is flagged as a peak.
- R8: The word for crossing n appears with et_strobe_o high for one clock. It appears on the fourth rising edge when counting the edge that accepts the first sample of crossing n+1 as the first. No strobe occurs at any other time, and no two strobes fall on adjacent clocks.
- R9: A write with cfg_addr_i[11]=1 sets coefficient c[cfg_addr_i[2:0]] to cfg_wdata_i[5:0]. A write with cfg_addr_i[11]=0 sets table entry cfg_addr_i[10:0] to cfg_wdata_i[7:0].
- R10: While run_i is high, cfg_we_i has no effect on coefficients or table contents.
- R11: While smp_vld_i is low, smp_i and xing_i have no effect, and the phase count holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast clock (four samples per crossing) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Run enable; high locks configuration |
| smp_i | input | 10 | ADC sample |
| smp_vld_i | input | 1 | Sample valid |
| xing_i | input | 1 | Marks the first sample of a crossing |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | 12 | Configuration address (bit 11 selects coefficient vs table) |
| cfg_wdata_i | input | 8 | Configuration write data |
| et_o | output | 8 | Transverse-energy word of the finished crossing |
| et_strobe_o | output | 1 | One-clock strobe per crossing |

## Verification
The bench targets a flat-topped pulse. A detector with the comparisons swapped would report two peaks or none there, so it would emit two table words or a zero. It drives large values on the odd phases, which a filter without decimation would pick up. It drives sums both far above range and below zero, where wrap-around would give small or huge indices and read the wrong table entry. It also drives a peak on the early half, so an off-by-one in crossing assignment shifts the word to the neighbouring crossing. Writes attempted during a run, and idle cycles with a crossing strobe but no valid sample, check that locked configuration and a stalled phase count do not move the output. The strobe is also checked against an exact clock, which catches a missing or extra pipeline register.

// File: rtl/tt_filt_pkg.sv
package tt_filt_pkg;
  localparam int unsigned DEF_SAMPLE_W = 10;
  localparam int unsigned DEF_COEF_W   = 6;
  localparam int unsigned DEF_TAPS     = 8;
  localparam int unsigned DEF_FILT_W   = 11;
  localparam int unsigned DEF_ET_W     = 8;

  typedef enum logic {
    CFG_TABLE = 1'b0,
    CFG_COEF  = 1'b1
  } cfg_sel_e;

  typedef enum logic {
    HALF_EARLY = 1'b0,
    HALF_LATE  = 1'b1
  } xing_half_e;
endpackage

// File: rtl/tt_fir.sv
module tt_fir
  import tt_filt_pkg::*;
#(
  parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
  parameter int unsigned COEF_W   = DEF_COEF_W,
  parameter int unsigned TAPS     = DEF_TAPS,
  parameter int unsigned OUT_W    = DEF_FILT_W,
  localparam int unsigned TAP_AW  = $clog2(TAPS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic [SAMPLE_W-1:0] smp_i,
  input  logic                smp_vld_i,
  input  logic                xing_i,
  input  logic                coef_we_i,
  input  logic [TAP_AW-1:0]   coef_addr_i,
  input  logic [COEF_W-1:0]   coef_wdata_i,
  output logic [OUT_W-1:0]    fir_o,
  output logic                fir_vld_o,
  output logic                fir_half_o,
  output logic                load_h0_o
);
  localparam int unsigned ACC_W = SAMPLE_W + COEF_W + 1 + TAP_AW;

  logic [1:0] phase_q, cur_ph;
  logic       take, take_q, half_q;
  logic [TAPS-1:0][SAMPLE_W-1:0] tap_q;
  logic [TAPS-1:0][COEF_W-1:0]   coef_q;
  logic signed [ACC_W-1:0] prod [TAPS];
  logic signed [ACC_W-1:0] acc;
  logic [OUT_W-1:0]        sat;
  logic [OUT_W-1:0]        fir_q;
  logic                    fir_vld_q, fir_half_q;

  // phase restarts on the crossing mark, advances only on valid samples
  assign cur_ph    = xing_i ? 2'd0 : phase_q;
  assign take      = smp_vld_i && !cur_ph[0];
  assign load_h0_o = take && !cur_ph[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        phase_q <= 2'd0;
    else if (smp_vld_i) phase_q <= cur_ph + 2'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tap_q  <= '0;
      half_q <= HALF_EARLY;
      take_q <= 1'b0;
    end else begin
      take_q <= take;
      if (take) begin
        tap_q  <= {tap_q[TAPS-2:0], smp_i};
        half_q <= cur_ph[1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        coef_q <= '0;
    else if (coef_we_i) coef_q[coef_addr_i] <= coef_wdata_i;
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    assign prod[k] = $signed({{(ACC_W-SAMPLE_W){1'b0}}, tap_q[k]})
                   * $signed({{(ACC_W-COEF_W){coef_q[k][COEF_W-1]}}, coef_q[k]});
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < TAPS; k++) acc = acc + prod[k];
  end

  // clamp: negative to zero, beyond range to full scale
  always_comb begin
    if (acc[ACC_W-1])                 sat = '0;
    else if (|acc[ACC_W-2:OUT_W])     sat = '1;
    else                              sat = acc[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fir_q      <= '0;
      fir_vld_q  <= 1'b0;
      fir_half_q <= HALF_EARLY;
    end else begin
      fir_vld_q <= take_q;
      if (take_q) begin
        fir_q      <= sat;
        fir_half_q <= half_q;
      end
    end
  end

  assign fir_o      = fir_q;
  assign fir_vld_o  = fir_vld_q;
  assign fir_half_o = fir_half_q;

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> $stable(coef_q)); // R10
  AST_FIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_vld_i |=> $stable(phase_q)); // R11
endmodule

// File: rtl/tt_peak.sv
module tt_peak
  import tt_filt_pkg::*;
#(
  parameter int unsigned W = DEF_FILT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] fir_i,
  input  logic         fir_vld_i,
  input  logic         fir_half_i,
  output logic         pk_vld_o,
  output logic         pk_hit_o,
  output logic [W-1:0] pk_val_o,
  output logic         pk_half_o
);
  logic [W-1:0] y_mid_q, y_old_q, pk_val_q;
  logic         mid_half_q, mid_ok_q;
  logic         pk_vld_q, pk_hit_q, pk_half_q;
  logic         is_peak;

  // strict rise into the middle, non-strict fall after it
  assign is_peak = mid_ok_q && (y_mid_q > y_old_q) && (y_mid_q >= fir_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_mid_q    <= '0;
      y_old_q    <= '0;
      mid_half_q <= HALF_EARLY;
      mid_ok_q   <= 1'b0;
      pk_vld_q   <= 1'b0;
      pk_hit_q   <= 1'b0;
      pk_val_q   <= '0;
      pk_half_q  <= HALF_EARLY;
    end else begin
      pk_vld_q <= fir_vld_i && mid_ok_q;
      if (fir_vld_i) begin
        y_old_q    <= y_mid_q;
        y_mid_q    <= fir_i;
        mid_half_q <= fir_half_i;
        mid_ok_q   <= 1'b1;
        pk_hit_q   <= is_peak;
        pk_val_q   <= y_mid_q;
        pk_half_q  <= mid_half_q;
      end
    end
  end

  assign pk_vld_o  = pk_vld_q;
  assign pk_hit_o  = pk_hit_q;
  assign pk_val_o  = pk_val_q;
  assign pk_half_o = pk_half_q;

  AST_PEAK_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pk_vld_o && pk_hit_o) |-> (pk_val_o != '0)); // R5
endmodule

// File: rtl/tt_et_lut.sv
module tt_et_lut
  import tt_filt_pkg::*;
#(
  parameter int unsigned IDX_W = DEF_FILT_W,
  parameter int unsigned ET_W  = DEF_ET_W,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             pk_vld_i,
  input  logic             pk_hit_i,
  input  logic [IDX_W-1:0] pk_val_i,
  input  logic             pk_half_i,
  input  logic             lut_we_i,
  input  logic [IDX_W-1:0] lut_addr_i,
  input  logic [ET_W-1:0]  lut_wdata_i,
  output logic [ET_W-1:0]  et_o,
  output logic             et_strobe_o
);
  logic [ET_W-1:0]  lut_mem [DEPTH];
  logic             early_hit_q;
  logic [IDX_W-1:0] early_val_q;
  logic [ET_W-1:0]  et_q;
  logic             strobe_q;
  logic             late_dec, sel_hit;
  logic [IDX_W-1:0] sel_idx;

  always_ff @(posedge clk_i) begin
    if (lut_we_i) lut_mem[lut_addr_i] <= lut_wdata_i;
  end

  assign late_dec = pk_vld_i && (pk_half_i == HALF_LATE);
  assign sel_hit  = pk_hit_i || early_hit_q;
  assign sel_idx  = pk_hit_i ? pk_val_i : early_val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      early_hit_q <= 1'b0;
      early_val_q <= '0;
      et_q        <= '0;
      strobe_q    <= 1'b0;
    end else begin
      strobe_q <= late_dec;
      if (pk_vld_i && (pk_half_i == HALF_EARLY)) begin
        early_hit_q <= pk_hit_i;
        early_val_q <= pk_val_i;
      end
      if (late_dec) begin
        et_q        <= sel_hit ? lut_mem[sel_idx] : '0;
        early_hit_q <= 1'b0;
      end
    end
  end

  assign et_o        = et_q;
  assign et_strobe_o = strobe_q;

  AST_ONE_PEAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (late_dec && pk_hit_i) |-> !early_hit_q); // R7
  AST_LUT_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> !lut_we_i); // R10
endmodule

// File: rtl/tt_filter_chain.sv
module tt_filter_chain
  import tt_filt_pkg::*;
#(
  parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
  parameter int unsigned COEF_W   = DEF_COEF_W,
  parameter int unsigned TAPS     = DEF_TAPS,
  parameter int unsigned FILT_W   = DEF_FILT_W,
  parameter int unsigned ET_W     = DEF_ET_W,
  localparam int unsigned CFG_AW  = FILT_W + 1,
  localparam int unsigned DATA_W  = (ET_W > COEF_W) ? ET_W : COEF_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic [SAMPLE_W-1:0] smp_i,
  input  logic                smp_vld_i,
  input  logic                xing_i,
  input  logic                cfg_we_i,
  input  logic [CFG_AW-1:0]   cfg_addr_i,
  input  logic [DATA_W-1:0]   cfg_wdata_i,
  output logic [ET_W-1:0]     et_o,
  output logic                et_strobe_o
);
  localparam int unsigned TAP_AW = $clog2(TAPS);

  cfg_sel_e          cfg_sel;
  logic              coef_we, lut_we;
  logic [FILT_W-1:0] fir;
  logic              fir_vld, fir_half, load_h0;
  logic              pk_vld, pk_hit, pk_half;
  logic [FILT_W-1:0] pk_val;

  assign cfg_sel = cfg_sel_e'(cfg_addr_i[CFG_AW-1]);
  assign coef_we = cfg_we_i && !run_i && (cfg_sel == CFG_COEF);
  assign lut_we  = cfg_we_i && !run_i && (cfg_sel == CFG_TABLE);

  tt_fir #(
    .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .TAPS(TAPS), .OUT_W(FILT_W)
  ) u_fir (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run_i),
    .smp_i        (smp_i),
    .smp_vld_i    (smp_vld_i),
    .xing_i       (xing_i),
    .coef_we_i    (coef_we),
    .coef_addr_i  (cfg_addr_i[TAP_AW-1:0]),
    .coef_wdata_i (cfg_wdata_i[COEF_W-1:0]),
    .fir_o        (fir),
    .fir_vld_o    (fir_vld),
    .fir_half_o   (fir_half),
    .load_h0_o    (load_h0)
  );

  tt_peak #(.W(FILT_W)) u_peak (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fir_i      (fir),
    .fir_vld_i  (fir_vld),
    .fir_half_i (fir_half),
    .pk_vld_o   (pk_vld),
    .pk_hit_o   (pk_hit),
    .pk_val_o   (pk_val),
    .pk_half_o  (pk_half)
  );

  tt_et_lut #(.IDX_W(FILT_W), .ET_W(ET_W)) u_et (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_i),
    .pk_vld_i    (pk_vld),
    .pk_hit_i    (pk_hit),
    .pk_val_i    (pk_val),
    .pk_half_i   (pk_half),
    .lut_we_i    (lut_we),
    .lut_addr_i  (cfg_addr_i[FILT_W-1:0]),
    .lut_wdata_i (cfg_wdata_i[ET_W-1:0]),
    .et_o        (et_o),
    .et_strobe_o (et_strobe_o)
  );

  AST_FIXED_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    et_strobe_o |-> $past(load_h0, 4)); // R8
  AST_STROBE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    et_strobe_o |=> !et_strobe_o); // R8
endmodule

// File: tb/tt_filter_chain_tb_top.sv
`timescale 1ns/1ps
module tt_filter_chain_tb_top;
  localparam int WD_LIMIT = 150000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       run_i = 1'b0;
  logic [9:0] smp_i = '0;
  logic       smp_vld_i = 1'b0;
  logic       xing_i = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [11:0] cfg_addr_i = '0;
  logic [7:0] cfg_wdata_i = '0;
  logic [7:0] et_o;
  logic       et_strobe_o;

  always #4 clk_i = ~clk_i;

  tt_filter_chain dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .smp_i(smp_i),
    .smp_vld_i(smp_vld_i), .xing_i(xing_i), .cfg_we_i(cfg_we_i),
    .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .et_o(et_o), .et_strobe_o(et_strobe_o)
  );

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  string cur_tag = "R1";

  // reference model state
  int  coef_m [8];
  int  lut_m [2048];
  int  xh [8];
  int  y_mid, y_old, mid_half, early_val;
  bit  mid_ok, early_hit;
  int  due_q [$];
  int  val_q [$];
  string tag_q [$];

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk_i) begin
    if (cyc == WD_LIMIT) begin
      chk(0, "watchdog", cyc, WD_LIMIT);
      summary();
      $finish;
    end
  end

  // output monitor: each strobe must match the next expected word on its exact cycle (R8)
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (due_q.size() > 0 && due_q[0] < cyc) begin
        chk(0, {"R8 missing strobe ", tag_q[0]}, 0, 1);
        void'(due_q.pop_front()); void'(val_q.pop_front()); void'(tag_q.pop_front());
      end
      if (et_strobe_o) begin
        if (due_q.size() > 0 && due_q[0] == cyc) begin
          chk(et_o == val_q[0][7:0], tag_q[0], int'(et_o), val_q[0]);
          void'(due_q.pop_front()); void'(val_q.pop_front()); void'(tag_q.pop_front());
        end else begin
          chk(0, "R8 unexpected strobe", 1, 0);
        end
      end
    end
  end

  function automatic int sat_fn(int s);
    if (s < 0) return 0;
    if (s > 2047) return 2047;
    return s;
  endfunction

  // one filter input (R3, R4), peak rule (R5), crossing assignment (R6)
  task automatic model_take(int s, int half);
    int acc = 0;
    int y;
    bit pk;
    for (int k = 7; k > 0; k--) xh[k] = xh[k-1];
    xh[0] = s;
    for (int k = 0; k < 8; k++) acc += coef_m[k] * xh[k];
    y = sat_fn(acc);
    if (mid_ok) begin
      pk = (y_mid > y_old) && (y_mid >= y);
      if (mid_half == 0) begin
        early_hit = pk;
        early_val = y_mid;
      end else begin
        due_q.push_back(cyc + 4);
        val_q.push_back(pk ? lut_m[y_mid] : (early_hit ? lut_m[early_val] : 0));
        tag_q.push_back(cur_tag);
        early_hit = 0;
      end
    end
    y_old = y_mid; y_mid = y; mid_half = half; mid_ok = 1;
  endtask

  task automatic cfg_wr(int addr, int data);
    @(negedge clk_i);
    smp_vld_i = 0; xing_i = 0;
    cfg_we_i = 1; cfg_addr_i = addr[11:0]; cfg_wdata_i = data[7:0];
    if (!run_i) begin // R9 map, R10 lock
      if (addr >= 2048) coef_m[addr & 7] = ((data & 63) >= 32) ? (data & 63) - 64 : (data & 63);
      else lut_m[addr & 2047] = data & 255;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      cfg_we_i = 0; smp_vld_i = 0;
      smp_i = 10'($urandom);
      xing_i = 1'($urandom); // R11: no effect without valid
    end
  endtask

  task automatic put_smp(int s, bit x, int ph);
    @(negedge clk_i);
    cfg_we_i = 0; smp_vld_i = 1; xing_i = x; smp_i = s[9:0];
    if (ph % 2 == 0) model_take(s, ph / 2);
  endtask

  task automatic crossing(int a, int b, int c, int d, int gap);
    put_smp(a, 1, 0); idle(gap);
    put_smp(b, 0, 1); idle(gap);
    put_smp(c, 0, 2); idle(gap);
    put_smp(d, 0, 3); idle(gap);
  endtask

  task automatic set_coefs_single(int c0);
    cfg_wr(2048, c0 & 63);
    for (int k = 1; k < 8; k++) cfg_wr(2048 + k, 0);
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    for (int k = 0; k < 8; k++) begin coef_m[k] = 0; xh[k] = 0; end
    y_mid = 0; y_old = 0; mid_half = 0; mid_ok = 0; early_hit = 0; early_val = 0;

    repeat (3) @(negedge clk_i);
    chk(et_o == 0 && et_strobe_o == 0, "R1 in reset", int'(et_o), 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk(et_o == 0 && et_strobe_o == 0, "R1 after release", int'(et_o), 0);

    // R9: table and coefficient loading while stopped
    for (int i = 0; i < 2048; i++) cfg_wr(i, (i * 37 + 11) & 255);
    set_coefs_single(1);
    idle(2);
    chk(et_strobe_o == 0, "R1 idle before samples", int'(et_strobe_o), 0);
    run_i = 1;

    cur_tag = "R2 odd phases ignored";
    crossing(0, 1023, 0, 1023, 0);
    crossing(0, 1023, 0, 1023, 0);
    cur_tag = "R5 plateau";
    crossing(0, 900, 40, 900, 0);
    crossing(40, 900, 0, 900, 0);
    crossing(0, 0, 0, 0, 0);
    cur_tag = "R6 early-half peak";
    crossing(0, 5, 50, 5, 0);
    crossing(80, 5, 20, 5, 0);
    crossing(0, 0, 0, 0, 0);
    cur_tag = "R11 idle gaps";
    crossing(30, 7, 60, 7, 2);
    crossing(60, 7, 10, 7, 3);
    crossing(0, 0, 0, 0, 1);
    idle(6);

    // R10: writes during a run must not land
    cfg_wr(40, 8'hA5);
    cfg_wr(2048, 0);
    cur_tag = "R10 locked writes";
    crossing(0, 0, 40, 0, 0);
    crossing(0, 0, 0, 0, 0);
    idle(6);

    run_i = 0;
    set_coefs_single(31);
    idle(1);
    run_i = 1;
    cur_tag = "R4 saturation high";
    crossing(200, 0, 700, 0, 0);
    crossing(900, 0, 300, 0, 0);
    crossing(10, 0, 0, 0, 0);
    idle(6);

    run_i = 0;
    set_coefs_single(-3);
    idle(1);
    run_i = 1;
    cur_tag = "R4 clamp negative";
    crossing(500, 0, 900, 0, 0);
    crossing(100, 0, 1023, 0, 0);
    crossing(0, 0, 0, 0, 0);
    idle(6);

    // R3 and R7: random coefficient sets and pulses
    for (int set = 0; set < 4; set++) begin
      run_i = 0;
      for (int k = 0; k < 8; k++) begin
        int c;
        c = (set < 2) ? int'($urandom_range(7)) - 2 : int'($urandom_range(63)) - 32;
        cfg_wr(2048 + k, c & 63);
      end
      idle(1);
      run_i = 1;
      cur_tag = "R3 R7 random";
      for (int n = 0; n < 60; n++) begin
        int lim;
        lim = (set == 3) ? 63 : 1023;
        crossing(int'($urandom_range(lim)), int'($urandom_range(1023)),
                 int'($urandom_range(lim)), int'($urandom_range(1023)),
                 ($urandom_range(3) == 0) ? 1 : 0);
      end
      idle(6);
    end

    idle(8);
    chk(due_q.size() == 0, "R8 pending words", due_q.size(), 0);
    summary();
    $finish;
  end
endmodule